// File: doc/BRIEF.md
# Main RAM window decoder

This block sits on a CPU's two fetch paths, one for code and one for data. It decides what each request reaches inside the lowest 8 MB of three mirrored address segments. The segments are the user segment at 00000000h, the cached kernel segment at 80000000h and the uncached kernel segment at A0000000h. A 3-bit layout code splits that 8 MB into up to three regions, in this order: populated memory on the first row-select bank, a high-impedance region on the second row-select bank, and a locked region. The decoder reports the region class for each request. For a RAM hit it also reports the bank and the byte offset into that bank.

A locked access raises an error flag and selects no bank. A separate run input must be high for normal decoding; while it is low, every in-window access is treated as locked. An optional one-cycle stall can be enabled. It is raised when a code request and a data request both reach RAM in the same cycle. All results are registered and appear one clock after the request.

Top module: `ramwin_decoder`

## Requirements
- R1: While `rst_n` is low, every output is zero: class 0, bank 0, offset 0, error 0 and stall 0.
- R2: A request lies in the window only if address bits 31:29 are 000, 100 or 101 and bits 28:23 are all zero. Any other address yields class 0 (none), error 0, bank 0 and offset 0.
- R3: The layout code selects the sizes of the memory and high-Z regions, in MB: 0→1/0, 1→4/0, 2→1/1, 3→4/4, 4→2/0, 5→8/0, 6→2/2, 7→8/0. Whatever part of the 8 MB is left over is locked.
- R4: An in-window offset (address bits 22:0) below the memory size gives class 1 (memory), bank 0, and an output offset equal to address bits 22:0.
- R5: An offset inside the high-Z region gives class 2 (high-Z), bank 1, and an output offset equal to address bits 22:0 minus the memory size in bytes.
- R6: An offset at or beyond the end of the high-Z region gives class 3 (locked), error 1, bank 0 and offset 0.
- R7: While `cfg_run_i` is low, every valid in-window request gives class 3 with error 1.
- R8: Results appear one cycle after the request. A request with its valid low gives class 0 and error 0.
- R9: `stall_o` is 1 in the cycle after a cycle in which `cfg_stall_en_i` was 1 and both requests decoded to class 1 or 2. Otherwise it is 0.
- R10: The code and data paths use the same layout and decode independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_layout_i | input | 3 | Window layout code |
| cfg_stall_en_i | input | 1 | Enables the coincidence stall |
| cfg_run_i | input | 1 | Normal-operation enable; when low, in-window accesses are locked |
| code_req_i | input | 1 | Code request valid |
| code_addr_i | input | 32 | Code request address |
| data_req_i | input | 1 | Data request valid |
| data_addr_i | input | 32 | Data request address |
| code_class_o | output | 2 | Code result class: 0 none, 1 memory, 2 high-Z, 3 locked |
| code_bank_o | output | 1 | Code row-select bank |
| code_offset_o | output | 23 | Code offset within its bank |
| code_err_o | output | 1 | Code bus error |
| data_class_o | output | 2 | Data result class |
| data_bank_o | output | 1 | Data row-select bank |
| data_offset_o | output | 23 | Data offset within its bank |
| data_err_o | output | 1 | Data bus error |
| stall_o | output | 1 | One-cycle coincidence stall |

## Verification
Two things can happen in the same cycle: the two paths decode into different regions, and the stall decision is made from both results together. The bench provokes this by presenting both requests at once. It mixes memory with memory, memory with high-Z, and high-Z with locked, and repeats the same addresses with the stall enable both on and off. For each case it compares each path's class, bank and offset against sizes derived from the layout table, and checks that the stall rises only when both paths landed in RAM with stalling enabled. It also checks that the stall falls again on the following cycle.

// File: rtl/ramwin_pkg.sv
package ramwin_pkg;

  localparam int WIN_W    = 23;  // 8 MB window offset width
  localparam int MB_SHIFT = 20;  // region granularity: 1 MB
  localparam int SEG_W    = 3;   // segment selector width
  localparam int LAY_W    = 3;   // layout code width
  localparam int MB_W     = 4;   // region size in MB, 0..8

  typedef enum logic [1:0] {
    RW_NONE = 2'd0,
    RW_MEM  = 2'd1,
    RW_HIZ  = 2'd2,
    RW_LOCK = 2'd3
  } rw_class_e;

  typedef struct packed {
    rw_class_e        cls;
    logic             bank;
    logic [WIN_W-1:0] off;
  } rw_result_t;

  // Size of the populated region on the first bank, in MB.
  function automatic logic [MB_W-1:0] mem_mb(input logic [LAY_W-1:0] lay);
    case (lay)
      3'd0, 3'd2:        return 4'd1;
      3'd1, 3'd3:        return 4'd4;
      3'd4, 3'd6:        return 4'd2;
      default:           return 4'd8;
    endcase
  endfunction

  // Size of the high-impedance region on the second bank, in MB.
  function automatic logic [MB_W-1:0] hiz_mb(input logic [LAY_W-1:0] lay);
    case (lay)
      3'd2:    return 4'd1;
      3'd3:    return 4'd4;
      3'd6:    return 4'd2;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [WIN_W:0] mb_bytes(input logic [MB_W-1:0] mb);
    return (WIN_W+1)'(mb) << MB_SHIFT;
  endfunction

  function automatic logic [WIN_W:0] mem_limit(input logic [LAY_W-1:0] lay);
    return mb_bytes(mem_mb(lay));
  endfunction

  function automatic logic [WIN_W:0] hiz_limit(input logic [LAY_W-1:0] lay);
    return mb_bytes(mem_mb(lay)) + mb_bytes(hiz_mb(lay));
  endfunction

  function automatic logic is_ram(input rw_class_e c);
    return (c == RW_MEM) || (c == RW_HIZ);
  endfunction

endpackage

// File: rtl/ramwin_seg_match.sv
module ramwin_seg_match #(
  parameter int               SEG_W = 3,
  parameter int               GAP_W = 6,
  parameter logic [SEG_W-1:0] SEG_A = 3'b000,
  parameter logic [SEG_W-1:0] SEG_B = 3'b100,
  parameter logic [SEG_W-1:0] SEG_C = 3'b101
) (
  input  logic [SEG_W+GAP_W-1:0] upper_i,
  output logic                   in_window_o
);

  logic [SEG_W-1:0] seg;
  logic [GAP_W-1:0] gap;
  logic             seg_hit;

  assign seg = upper_i[SEG_W+GAP_W-1 -: SEG_W];
  assign gap = upper_i[GAP_W-1:0];

  always_comb begin
    seg_hit = (seg == SEG_A) || (seg == SEG_B) || (seg == SEG_C);
    in_window_o = seg_hit && (gap == '0);
  end

endmodule

// File: rtl/ramwin_classify.sv
module ramwin_classify
  import ramwin_pkg::*;
(
  input  logic             req_i,
  input  logic             in_window_i,
  input  logic             run_i,
  input  logic [LAY_W-1:0] layout_i,
  input  logic [WIN_W-1:0] off_i,
  output rw_result_t       res_o
);

  logic [WIN_W:0] mem_end;
  logic [WIN_W:0] hiz_end;
  logic [WIN_W:0] off_x;

  assign mem_end = mem_limit(layout_i);
  assign hiz_end = hiz_limit(layout_i);
  assign off_x   = {1'b0, off_i};

  always_comb begin
    res_o = '{cls: RW_NONE, bank: 1'b0, off: '0};
    if (req_i && in_window_i) begin
      if (!run_i) begin
        res_o.cls = RW_LOCK;
      end else if (off_x < mem_end) begin
        res_o.cls = RW_MEM;
        res_o.off = off_i;
      end else if (off_x < hiz_end) begin
        res_o.cls  = RW_HIZ;
        res_o.bank = 1'b1;
        res_o.off  = off_i - mem_end[WIN_W-1:0];
      end else begin
        res_o.cls = RW_LOCK;
      end
    end
  end

endmodule

// File: rtl/ramwin_stall.sv
module ramwin_stall (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic ram_a_i,
  input  logic ram_b_i,
  output logic stall_o
);

  logic coincide;
  assign coincide = ram_a_i && ram_b_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stall_o <= 1'b0;
    else        stall_o <= en_i && coincide;
  end

endmodule

// File: rtl/ramwin_decoder.sv
module ramwin_decoder
  import ramwin_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LAY_W-1:0]  cfg_layout_i,
  input  logic              cfg_stall_en_i,
  input  logic              cfg_run_i,
  input  logic              code_req_i,
  input  logic [ADDR_W-1:0] code_addr_i,
  input  logic              data_req_i,
  input  logic [ADDR_W-1:0] data_addr_i,
  output logic [1:0]        code_class_o,
  output logic              code_bank_o,
  output logic [WIN_W-1:0]  code_offset_o,
  output logic              code_err_o,
  output logic [1:0]        data_class_o,
  output logic              data_bank_o,
  output logic [WIN_W-1:0]  data_offset_o,
  output logic              data_err_o,
  output logic              stall_o
);

  localparam int NPORT = 2;  // 0: code, 1: data
  localparam int UP_W  = ADDR_W - WIN_W;
  localparam int GAP_W = UP_W - SEG_W;

  logic              req       [NPORT];
  logic [ADDR_W-1:0] addr      [NPORT];
  logic              in_window [NPORT];
  rw_result_t        res_d     [NPORT];
  rw_result_t        res_q     [NPORT];
  logic              err_q     [NPORT];
  logic              ram_hit   [NPORT];

  assign req[0]  = code_req_i;
  assign addr[0] = code_addr_i;
  assign req[1]  = data_req_i;
  assign addr[1] = data_addr_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    ramwin_seg_match #(
      .SEG_W (SEG_W),
      .GAP_W (GAP_W)
    ) u_seg (
      .upper_i     (addr[p][ADDR_W-1:WIN_W]),
      .in_window_o (in_window[p])
    );

    ramwin_classify u_cls (
      .req_i       (req[p]),
      .in_window_i (in_window[p]),
      .run_i       (cfg_run_i),
      .layout_i    (cfg_layout_i),
      .off_i       (addr[p][WIN_W-1:0]),
      .res_o       (res_d[p])
    );

    assign ram_hit[p] = is_ram(res_d[p].cls);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q[p] <= '{cls: RW_NONE, bank: 1'b0, off: '0};
        err_q[p] <= 1'b0;
      end else begin
        res_q[p] <= res_d[p];
        err_q[p] <= (res_d[p].cls == RW_LOCK);
      end
    end

    // R7: a halted block locks any in-window request
    p_halt_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req[p] && in_window[p] && !cfg_run_i) |-> res_q[p].cls == RW_LOCK);

    // R4: a memory hit never points past the populated region
    p_mem_offset_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      res_q[p].cls == RW_MEM |-> {1'b0, res_q[p].off} < mem_limit($past(cfg_layout_i)));

    // R8: no request, no result
    p_idle_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(req[p]) |-> res_q[p].cls == RW_NONE);

    // R6: error only with a locked result, and a locked result selects nothing
    p_err_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_q[p] |-> (res_q[p].cls == RW_LOCK && !res_q[p].bank && res_q[p].off == '0));

    // R5: high-Z always uses the second bank
    p_hiz_bank_r5: assert property (@(posedge clk) disable iff (!rst_n)
      res_q[p].cls == RW_HIZ |-> res_q[p].bank);
  end

  ramwin_stall u_stall (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (cfg_stall_en_i),
    .ram_a_i (ram_hit[0]),
    .ram_b_i (ram_hit[1]),
    .stall_o (stall_o)
  );

  // R9: a stall implies both registered results landed in RAM
  p_stall_both_ram_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (is_ram(res_q[0].cls) && is_ram(res_q[1].cls)));

  // R9: no stall when stalling was disabled
  p_stall_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cfg_stall_en_i) |-> !stall_o);

  assign code_class_o  = res_q[0].cls;
  assign code_bank_o   = res_q[0].bank;
  assign code_offset_o = res_q[0].off;
  assign code_err_o    = err_q[0];
  assign data_class_o  = res_q[1].cls;
  assign data_bank_o   = res_q[1].bank;
  assign data_offset_o = res_q[1].off;
  assign data_err_o    = err_q[1];

endmodule

// File: tb/ramwin_decoder_test.sv
module ramwin_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  typedef struct packed {
    logic [2:0]  lay;
    logic        sen;
    logic        run;
    logic        cv;
    logic [31:0] ca;
    logic        dv;
    logic [31:0] da;
    logic [1:0]  ccls;
    logic [22:0] coff;
    logic [1:0]  dcls;
    logic [22:0] doff;
    logic        stall;
  } vec_t;

  // class: 0 none, 1 memory, 2 high-Z, 3 locked (R2..R6); sizes per R3
  localparam vec_t VEC [NV] = '{
    {3'd5,1'b0,1'b1, 1'b1,32'h0000_1000, 1'b1,32'h807F_FFFC, 2'd1,23'h001000, 2'd1,23'h7FFFFC, 1'b0},
    {3'd0,1'b0,1'b1, 1'b1,32'h000F_FFFC, 1'b1,32'h0010_0000, 2'd1,23'h0FFFFC, 2'd3,23'h0,      1'b0},
    {3'd2,1'b0,1'b1, 1'b1,32'hA010_0004, 1'b1,32'h0020_0000, 2'd2,23'h000004, 2'd3,23'h0,      1'b0},
    {3'd3,1'b0,1'b1, 1'b1,32'h8040_0010, 1'b1,32'h003F_FFF0, 2'd2,23'h000010, 2'd1,23'h3FFFF0, 1'b0},
    {3'd6,1'b0,1'b1, 1'b1,32'h0020_0008, 1'b1,32'h0040_0000, 2'd2,23'h000008, 2'd3,23'h0,      1'b0},
    {3'd1,1'b0,1'b1, 1'b1,32'h0040_0000, 1'b1,32'h003F_FFFF, 2'd3,23'h0,      2'd1,23'h3FFFFF, 1'b0},
    {3'd4,1'b0,1'b1, 1'b1,32'h001F_FFFF, 1'b1,32'h0020_0000, 2'd1,23'h1FFFFF, 2'd3,23'h0,      1'b0},
    {3'd7,1'b0,1'b1, 1'b1,32'hA07F_FFFF, 1'b1,32'h0080_0000, 2'd1,23'h7FFFFF, 2'd0,23'h0,      1'b0},
    {3'd5,1'b0,1'b1, 1'b1,32'h2000_0000, 1'b1,32'hC000_0000, 2'd0,23'h0,      2'd0,23'h0,      1'b0},
    {3'd5,1'b0,1'b1, 1'b1,32'h9000_0000, 1'b1,32'hA080_0000, 2'd0,23'h0,      2'd0,23'h0,      1'b0},
    {3'd5,1'b1,1'b1, 1'b1,32'h0000_0100, 1'b1,32'h8000_0200, 2'd1,23'h000100, 2'd1,23'h000200, 1'b1},
    {3'd5,1'b0,1'b1, 1'b1,32'h0000_0100, 1'b1,32'h8000_0200, 2'd1,23'h000100, 2'd1,23'h000200, 1'b0},
    {3'd6,1'b1,1'b1, 1'b1,32'h0020_0000, 1'b1,32'h0040_0000, 2'd2,23'h0,      2'd3,23'h0,      1'b0},
    {3'd6,1'b1,1'b1, 1'b1,32'h0000_0000, 1'b1,32'h0020_0004, 2'd1,23'h0,      2'd2,23'h000004, 1'b1},
    {3'd3,1'b1,1'b0, 1'b1,32'h0000_0000, 1'b1,32'h0000_0100, 2'd3,23'h0,      2'd3,23'h0,      1'b0},
    {3'd5,1'b1,1'b1, 1'b0,32'h0000_0100, 1'b1,32'h0000_0100, 2'd0,23'h0,      2'd1,23'h000100, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_layout_i = '0;
  logic        cfg_stall_en_i = 1'b0;
  logic        cfg_run_i = 1'b0;
  logic        code_req_i = 1'b0;
  logic [31:0] code_addr_i = '0;
  logic        data_req_i = 1'b0;
  logic [31:0] data_addr_i = '0;
  logic [1:0]  code_class_o, data_class_o;
  logic        code_bank_o, data_bank_o, code_err_o, data_err_o, stall_o;
  logic [22:0] code_offset_o, data_offset_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramwin_decoder uut (
    .clk(clk), .rst_n(rst_n),
    .cfg_layout_i(cfg_layout_i), .cfg_stall_en_i(cfg_stall_en_i), .cfg_run_i(cfg_run_i),
    .code_req_i(code_req_i), .code_addr_i(code_addr_i),
    .data_req_i(data_req_i), .data_addr_i(data_addr_i),
    .code_class_o(code_class_o), .code_bank_o(code_bank_o),
    .code_offset_o(code_offset_o), .code_err_o(code_err_o),
    .data_class_o(data_class_o), .data_bank_o(data_bank_o),
    .data_offset_o(data_offset_o), .data_err_o(data_err_o),
    .stall_o(stall_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] cls, input logic run, input logic v);
    if (!v)          return "R8";
    if (cls == 2'd0) return "R2";
    if (!run)        return "R7";
    if (cls == 2'd1) return "R4";
    if (cls == 2'd2) return "R5";
    return "R6";
  endfunction

  // R10: each path checked against its own expectation under the shared layout
  task automatic chk_path(input string side, input logic [1:0] cls, input logic [22:0] off,
                          input logic run, input logic v,
                          input logic [1:0] a_cls, input logic a_bank,
                          input logic [22:0] a_off, input logic a_err);
    string t;
    t = tag_of(cls, run, v);
    chk(t, {side, " class"},  32'(a_cls),  32'(cls));
    chk(t, {side, " bank"},   32'(a_bank), 32'(cls == 2'd2));
    chk(t, {side, " offset"}, 32'(a_off),  32'(off));
    chk(t, {side, " err"},    32'(a_err),  32'(cls == 2'd3));
  endtask

  task automatic chk_reset_state(input string when);
    chk("R1", {when, " code class"}, 32'(code_class_o), 0);
    chk("R1", {when, " data class"}, 32'(data_class_o), 0);
    chk("R1", {when, " offsets"}, 32'(code_offset_o | data_offset_o), 0);
    chk("R1", {when, " err/bank"}, 32'({code_err_o, data_err_o, code_bank_o, data_bank_o}), 0);
    chk("R1", {when, " stall"}, 32'(stall_o), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk_reset_state("in reset");
    @(negedge clk) rst_n = 1'b1;

    // Table walk: drive on the falling edge, sample just after the next rising edge
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      cfg_layout_i = VEC[i].lay;  cfg_stall_en_i = VEC[i].sen;  cfg_run_i = VEC[i].run;
      code_req_i = VEC[i].cv;  code_addr_i = VEC[i].ca;
      data_req_i = VEC[i].dv;  data_addr_i = VEC[i].da;
      @(posedge clk);
      #1;
      chk_path("code", VEC[i].ccls, VEC[i].coff, VEC[i].run, VEC[i].cv,
               code_class_o, code_bank_o, code_offset_o, code_err_o);
      chk_path("data", VEC[i].dcls, VEC[i].doff, VEC[i].run, VEC[i].dv,
               data_class_o, data_bank_o, data_offset_o, data_err_o);
      chk("R9", "stall", 32'(stall_o), 32'(VEC[i].stall));
    end

    // R9: stall lasts one cycle once the coincidence is gone
    @(negedge clk);
    cfg_layout_i = 3'd5; cfg_stall_en_i = 1'b1; cfg_run_i = 1'b1;
    code_req_i = 1'b1; code_addr_i = 32'h0000_0040;
    data_req_i = 1'b1; data_addr_i = 32'hA000_0080;
    @(posedge clk); #1 chk("R9", "coincident stall", 32'(stall_o), 1);
    @(negedge clk) data_req_i = 1'b0;
    @(posedge clk); #1 chk("R9", "stall released", 32'(stall_o), 0);
    chk("R8", "dropped data request", 32'(data_class_o), 0);
    chk("R4", "lone code hit", 32'(code_offset_o), 32'h40);

    // R1: reset in the middle of a run clears everything at once
    @(negedge clk) data_req_i = 1'b1;
    @(posedge clk); #1 chk("R9", "stall before reset", 32'(stall_o), 1);
    @(negedge clk) rst_n = 1'b0;
    #1 chk_reset_state("mid-run reset");
    @(negedge clk);
    code_req_i = 1'b0; data_req_i = 1'b0; rst_n = 1'b1;
    @(posedge clk); #1 chk("R8", "idle after reset", 32'(code_class_o | data_class_o), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule